// File: doc/BRIEF.md
# Multi-Mode Raster Test Pattern Generator

This block sits in a pixel stream and, when enabled with a legal configuration, replaces the incoming image with a synthetic test pattern. It can also leave the image visible in the background. The raster is described by three strobes: a frame strobe, a line strobe and a per-pixel valid. The first line after each frame strobe carries frame information and is never touched. Counting starts on the line that follows it. One 12-bit pixel leaves the block for every valid input pixel, one clock later.

Eleven pattern modes are selected by an 8-bit code. They cover a grid of points whose levels rise in steps, two fixed repeating sequences, a per-line ramp, single rows and columns, stripes, a checkerboard, and colour bars running in either direction. The geometry and levels of every mode are plain inputs. Every value the pattern path emits is clipped to the legal code range 001h to FFEh. An illegal mode or illegal setting makes the block a transparent one-cycle delay.

Top module: `test_pattern_gen`

## Requirements
- R1: `out_vld` equals `pix_vld` delayed by one clock, and `pix_out` belongs to the pixel presented one clock earlier. A `frame_start` pulse arms an information line: the pixels of the next line (the one opened by the next `line_start`) pass unchanged. The line after that is row 0, and column 0 is the first valid pixel after its `line_start`. The strobes never share a cycle with each other or with `pix_vld`.
- R2: Every pixel produced by the pattern path, including pass-through background, is clipped: values below 001h become 001h and values above FFEh become FFEh.
- R3: Mode 00h (grid). Points lie at columns `h_pos + i*h_step` for i < `h_num`, and at rows `v_pos + j*v_step` for j < `v_num`. In raster order the first point is `data1` and each later point adds `data2`. A sum above FFEh restarts the sequence at `data1`. A step or count of zero is illegal.
- R4: Mode 01h repeats FFEh, 555h, AAAh, 001h per pixel from column 0. Mode 02h repeats FFEh, FFEh, FC0h, FC0h, C3Ch, C3Ch, 333h, 333h, AAAh, AAAh, 001h, FFEh.
- R5: Mode 03h is a ramp that starts at 001h on every line and adds 1, 2 or 4 per pixel for `grad_step` = 0, 1 or 2. A sum above FFEh returns it to 001h. A `grad_step` of 3 is illegal.
- R6: Mode 04h draws `data1` on row `v_pos`. Mode 05h draws `data1` on column `h_pos`. Mode 06h draws `data1` on column `h_pos`, which wins at the crossing, and `data2` on row `v_pos`.
- R7: When `bg_thru` is 0, non-pattern pixels are 0 in modes 00h and 06h and `data2` in modes 04h and 05h. When `bg_thru` is 1, they are the incoming pixel.
- R8: Mode 07h gives `data1` on even columns and `data2` on odd ones. Mode 08h gives `data1` where column+row is even and `data2` where it is odd.
- R9: Modes 0Ah and 0Bh draw bars `bar_width*16` pixels wide, across columns (0Ah) or rows (0Bh). Bar n shows level n mod 8 from the list 001h, 249h, 492h, 6DBh, 923h, B6Ch, DB5h, FFEh. A `bar_width` below 2 is illegal.
- R10: With `pg_en` low, an unlisted mode code, or an illegal setting, `pix_out` is the raw input pixel, unclipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_en | input | 1 | Pattern enable |
| mode | input | 8 | Pattern mode code |
| bg_thru | input | 1 | Background shows the incoming image |
| grad_step | input | 2 | Ramp increment code |
| bar_width | input | 8 | Colour bar width in units of 16 pixels |
| h_pos | input | 12 | Horizontal position / grid start column |
| v_pos | input | 12 | Vertical position / grid start row |
| h_step | input | 12 | Grid column spacing |
| v_step | input | 12 | Grid row spacing |
| h_num | input | 8 | Grid points per row |
| v_num | input | 8 | Grid point rows |
| data1 | input | 12 | First pattern level |
| data2 | input | 12 | Second pattern level / grid increment |
| frame_start | input | 1 | Frame strobe |
| line_start | input | 1 | Line strobe |
| pix_vld | input | 1 | Input pixel valid |
| pix_in | input | 12 | Incoming image pixel |
| out_vld | output | 1 | Output pixel valid |
| pix_out | output | 12 | Output pixel |

## Verification
The assertions check three things on every cycle. The output valid tracks the input valid with a one-clock delay. An in-range input never yields an out-of-range output. A disabled block, or an unlisted mode, forwards the input pixel exactly, and sequence 1 only ever emits its four levels. Whether each pixel carries the right value for its position can only be shown by the bench's sweeps over whole frames. Those sweeps cover grid wrap-around, ramp wrap for each increment, bar boundaries, background selection and the information line.

// File: rtl/test_pattern_gen.sv
module test_pattern_gen #(
  parameter int PW = 12,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pg_en,
  input  logic [7:0]    mode,
  input  logic          bg_thru,
  input  logic [1:0]    grad_step,
  input  logic [7:0]    bar_width,
  input  logic [CW-1:0] h_pos,
  input  logic [CW-1:0] v_pos,
  input  logic [CW-1:0] h_step,
  input  logic [CW-1:0] v_step,
  input  logic [7:0]    h_num,
  input  logic [7:0]    v_num,
  input  logic [PW-1:0] data1,
  input  logic [PW-1:0] data2,
  input  logic          frame_start,
  input  logic          line_start,
  input  logic          pix_vld,
  input  logic [PW-1:0] pix_in,
  output logic          out_vld,
  output logic [PW-1:0] pix_out
);
  localparam logic [PW-1:0] LO = PW'(1);
  localparam logic [PW-1:0] HI = {{(PW-1){1'b1}}, 1'b0};
  localparam int BW = PW + 3;

  logic fs_seen, info_line, act;
  logic [CW-1:0] hc, vc, hgap, vgap, hbc, vbc;
  logic [7:0] hidx, vidx;
  logic [PW-1:0] gval, grad;
  logic [3:0] s12;
  logic [2:0] hbi, vbi;

  function automatic logic [PW-1:0] clip(input logic [PW-1:0] v);
    return (v < LO) ? LO : ((v > HI) ? HI : v);
  endfunction

  function automatic logic [PW-1:0] bar_lvl(input logic [2:0] i);
    logic [BW-1:0] t;
    t = (BW'(HI - LO) * BW'(i)) / BW'(7) + BW'(1);
    return t[PW-1:0];
  endfunction

  function automatic logic [PW-1:0] seq1(input logic [1:0] i);
    case (i)
      2'd0: return PW'(12'hFFE);
      2'd1: return PW'(12'h555);
      2'd2: return PW'(12'hAAA);
      default: return PW'(12'h001);
    endcase
  endfunction

  function automatic logic [PW-1:0] seq2(input logic [3:0] i);
    case (i)
      4'd0, 4'd1, 4'd11: return PW'(12'hFFE);
      4'd2, 4'd3:        return PW'(12'hFC0);
      4'd4, 4'd5:        return PW'(12'hC3C);
      4'd6, 4'd7:        return PW'(12'h333);
      4'd8, 4'd9:        return PW'(12'hAAA);
      default:           return PW'(12'h001);
    endcase
  endfunction

  wire row_hit = (vgap == '0) && (vidx < v_num);
  wire col_hit = (hgap == '0) && (hidx < h_num);
  wire pt      = row_hit && col_hit;
  wire [CW-1:0] bw = {bar_width, 4'b0000};

  wire [PW:0] gsum  = {1'b0, gval} + {1'b0, data2};
  wire [PW-1:0] gwrap = (gsum > {1'b0, HI}) ? data1 : gsum[PW-1:0];
  wire [PW:0] rsum  = {1'b0, grad} + ((PW+1)'(1) << grad_step);
  wire [PW-1:0] rnext = (rsum > {1'b0, HI}) ? LO : rsum[PW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_seen <= 1'b0; info_line <= 1'b0; act <= 1'b0;
      hc <= '0; vc <= '0; hgap <= '0; vgap <= '0; hidx <= '0; vidx <= '0;
      gval <= '0; grad <= LO; s12 <= '0;
      hbc <= '0; vbc <= '0; hbi <= '0; vbi <= '0;
    end else if (frame_start) begin
      fs_seen <= 1'b1; info_line <= 1'b0; act <= 1'b0;
    end else if (line_start) begin
      hc <= '0; hgap <= h_pos; hidx <= '0; s12 <= '0; grad <= LO;
      hbc <= '0; hbi <= '0;
      if (fs_seen) begin
        fs_seen <= 1'b0; info_line <= 1'b1; act <= 1'b0;
      end else if (info_line) begin
        info_line <= 1'b0; act <= 1'b1;
        vc <= '0; vgap <= v_pos; vidx <= '0; gval <= data1;
        vbc <= '0; vbi <= '0;
      end else if (act) begin
        vc <= vc + 1'b1;
        if (row_hit) begin
          vgap <= v_step - 1'b1; vidx <= vidx + 1'b1;
        end else if (vgap != '0) begin
          vgap <= vgap - 1'b1;
        end
        if (vbc >= bw - 1'b1) begin
          vbc <= '0; vbi <= vbi + 1'b1;
        end else begin
          vbc <= vbc + 1'b1;
        end
      end
    end else if (pix_vld) begin
      hc <= hc + 1'b1;
      s12 <= (s12 == 4'd11) ? 4'd0 : s12 + 4'd1;
      grad <= rnext;
      if (col_hit) begin
        hgap <= h_step - 1'b1; hidx <= hidx + 1'b1;
      end else if (hgap != '0) begin
        hgap <= hgap - 1'b1;
      end
      if (act && pt) gval <= gwrap;
      if (hbc >= bw - 1'b1) begin
        hbc <= '0; hbi <= hbi + 1'b1;
      end else begin
        hbc <= hbc + 1'b1;
      end
    end
  end

  logic legal;
  always_comb begin
    case (mode)
      8'h00: legal = (h_step != '0) && (v_step != '0) && (h_num != '0) && (v_num != '0);
      8'h01, 8'h02, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08: legal = 1'b1;
      8'h03: legal = (grad_step != 2'd3);
      8'h0A, 8'h0B: legal = (bar_width > 8'd1);
      default: legal = 1'b0;
    endcase
  end

  wire [PW-1:0] bg0 = bg_thru ? pix_in : '0;
  wire [PW-1:0] bgd = bg_thru ? pix_in : data2;
  wire on_row = (vc == v_pos);
  wire on_col = (hc == h_pos);

  logic [PW-1:0] pat;
  always_comb begin
    case (mode)
      8'h00:   pat = pt ? gval : bg0;
      8'h01:   pat = seq1(hc[1:0]);
      8'h02:   pat = seq2(s12);
      8'h03:   pat = grad;
      8'h04:   pat = on_row ? data1 : bgd;
      8'h05:   pat = on_col ? data1 : bgd;
      8'h06:   pat = on_col ? data1 : (on_row ? data2 : bg0);
      8'h07:   pat = hc[0] ? data2 : data1;
      8'h08:   pat = (hc[0] ^ vc[0]) ? data2 : data1;
      8'h0A:   pat = bar_lvl(hbi);
      default: pat = bar_lvl(vbi);
    endcase
  end

  wire use_pat = pg_en && act && legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      pix_out <= '0;
    end else begin
      out_vld <= pix_vld;
      if (pix_vld) pix_out <= use_pat ? clip(pat) : pix_in;
    end
  end
endmodule

module tpg_checker #(
  parameter int PW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pg_en,
  input logic [7:0]    mode,
  input logic          act,
  input logic          pix_vld,
  input logic [PW-1:0] pix_in,
  input logic          out_vld,
  input logic [PW-1:0] pix_out
);
  localparam logic [PW-1:0] LO = PW'(1);
  localparam logic [PW-1:0] HI = {{(PW-1){1'b1}}, 1'b0};

  AST_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_n) pix_vld |=> out_vld); // R1
  AST_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !pix_vld |=> !out_vld); // R1
  AST_RANGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && pix_in >= LO && pix_in <= HI) |=> (pix_out >= LO && pix_out <= HI)); // R2
  AST_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && !pg_en) |=> (pix_out == $past(pix_in))); // R10
  AST_BAD_MODE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && (mode == 8'h09 || mode > 8'h0B)) |=> (pix_out == $past(pix_in))); // R10
  AST_SEQ1_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && pg_en && act && mode == 8'h01) |=>
    (pix_out == PW'(12'hFFE) || pix_out == PW'(12'h555) ||
     pix_out == PW'(12'hAAA) || pix_out == PW'(12'h001))); // R4
endmodule

bind test_pattern_gen tpg_checker #(.PW(PW)) u_tpg_checker (
  .clk(clk), .rst_n(rst_n), .pg_en(pg_en), .mode(mode), .act(act),
  .pix_vld(pix_vld), .pix_in(pix_in), .out_vld(out_vld), .pix_out(pix_out)
);

// File: tb/test_test_pattern_gen.sv
module test_test_pattern_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pg_en = 1'b0, bg_thru = 1'b0;
  logic [7:0] mode = 8'h00, bar_width = 8'd2, h_num = 8'd1, v_num = 8'd1;
  logic [1:0] grad_step = 2'd0;
  logic [11:0] h_pos = '0, v_pos = '0, h_step = 12'd1, v_step = 12'd1;
  logic [11:0] data1 = '0, data2 = '0, pix_in = '0;
  logic frame_start = 1'b0, line_start = 1'b0, pix_vld = 1'b0;
  logic out_vld;
  logic [11:0] pix_out;
  int errors = 0, checks = 0;
  logic [11:0] s2 [12] = '{12'hFFE, 12'hFFE, 12'hFC0, 12'hFC0, 12'hC3C, 12'hC3C,
                           12'h333, 12'h333, 12'hAAA, 12'hAAA, 12'h001, 12'hFFE};
  logic [11:0] bars [8] = '{12'h001, 12'h249, 12'h492, 12'h6DB,
                            12'h923, 12'hB6C, 12'hDB5, 12'hFFE};
  string tag;

  always #10 clk = ~clk;

  test_pattern_gen i_test_pattern_gen (
    .clk(clk), .rst_n(rst_n), .pg_en(pg_en), .mode(mode), .bg_thru(bg_thru),
    .grad_step(grad_step), .bar_width(bar_width), .h_pos(h_pos), .v_pos(v_pos),
    .h_step(h_step), .v_step(v_step), .h_num(h_num), .v_num(v_num),
    .data1(data1), .data2(data2), .frame_start(frame_start), .line_start(line_start),
    .pix_vld(pix_vld), .pix_in(pix_in), .out_vld(out_vld), .pix_out(pix_out));

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] clip(input int v);
    if (v < 1) return 12'h001;
    if (v > 4094) return 12'hFFE;
    return 12'(v);
  endfunction

  function automatic logic is_legal();
    case (mode)
      8'h00: return h_step != 0 && v_step != 0 && h_num != 0 && v_num != 0;
      8'h01, 8'h02, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08: return 1'b1;
      8'h03: return grad_step != 2'd3;
      8'h0A, 8'h0B: return bar_width > 1;
      default: return 1'b0;
    endcase
  endfunction

  // Expected pixel from the requirements; sets tag to the governing requirement.
  function automatic logic [11:0] expect_px(input int x, input int y, input logic [11:0] pin);
    int v, bgz, bgd, w, ix, iy, k, p, inc;
    logic bg;
    if (y < 0) begin tag = "R1 info line"; return pin; end
    if (!pg_en || !is_legal()) begin tag = "R10 pass-through"; return pin; end
    bg = 1'b0;
    bgz = bg_thru ? int'(pin) : 0;
    bgd = bg_thru ? int'(pin) : int'(data2);
    w = int'(bar_width) * 16;
    case (mode)
      8'h00: begin
        tag = "R3 grid";
        if (x >= h_pos && (x - h_pos) % h_step == 0 && (x - h_pos) / h_step < h_num &&
            y >= v_pos && (y - v_pos) % v_step == 0 && (y - v_pos) / v_step < v_num) begin
          ix = (x - h_pos) / h_step; iy = (y - v_pos) / v_step;
          k = iy * h_num + ix;
          if (data2 == 0) v = data1;
          else begin
            p = (4094 - int'(data1)) / int'(data2) + 1;
            v = data1 + (k % p) * data2;
          end
        end else begin v = bgz; bg = 1'b1; end
      end
      8'h01: begin tag = "R4 seq1"; v = (x % 4 == 0) ? 12'hFFE : (x % 4 == 1) ? 12'h555 :
                                       (x % 4 == 2) ? 12'hAAA : 12'h001; end
      8'h02: begin tag = "R4 seq2"; v = s2[x % 12]; end
      8'h03: begin
        tag = "R5 ramp"; inc = 1 << grad_step;
        p = 4093 / inc + 1;
        v = 1 + (x % p) * inc;
      end
      8'h04: begin tag = "R6 row"; if (y == v_pos) v = data1; else begin v = bgd; bg = 1'b1; end end
      8'h05: begin tag = "R6 column"; if (x == h_pos) v = data1; else begin v = bgd; bg = 1'b1; end end
      8'h06: begin
        tag = "R6 row+column";
        if (x == h_pos) v = data1;
        else if (y == v_pos) v = data2;
        else begin v = bgz; bg = 1'b1; end
      end
      8'h07: begin tag = "R8 stripes"; v = (x % 2) ? data2 : data1; end
      8'h08: begin tag = "R8 checker"; v = ((x + y) % 2) ? data2 : data1; end
      8'h0A: begin tag = "R9 bars h"; v = bars[(x / w) % 8]; end
      default: begin tag = "R9 bars v"; v = bars[(y / w) % 8]; end
    endcase
    if (bg) tag = "R7 background";
    if (clip(v) != 12'(v) || v > 4095) tag = {"R2 clip / ", tag};
    return clip(v);
  endfunction

  task automatic strobe_line();
    @(negedge clk) line_start = 1'b1;
    @(negedge clk) line_start = 1'b0;
  endtask

  task automatic send_px(input int x, input int y, input int seed);
    logic [11:0] pin, e;
    pin = 12'((x * 293 + (y + 1) * 1031 + seed) & 12'hFFF);
    if ((x + seed) % 17 == 0) pin = 12'hFFF;
    if ((x + seed) % 19 == 0) pin = 12'h000;
    @(negedge clk) begin pix_vld = 1'b1; pix_in = pin; end
    @(negedge clk) begin
      pix_vld = 1'b0;
      e = expect_px(x, y, pin);
      check({tag, " valid"}, {11'b0, out_vld}, 12'd1);
      check(tag, pix_out, e);
    end
  endtask

  task automatic run_frame(input int w, input int h, input int seed);
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
    strobe_line();
    for (int x = 0; x < w; x++) send_px(x, -1, seed);
    for (int y = 0; y < h; y++) begin
      strobe_line();
      for (int x = 0; x < w; x++) send_px(x, y, seed);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #4000000;
    errors++; checks++;
    $display("FAIL watchdog: got hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {11'b0, out_vld}, 12'd0);
    check("R1 reset data", pix_out, 12'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle valid", {11'b0, out_vld}, 12'd0);

    // R10: disabled block
    pg_en = 1'b0; mode = 8'h07; run_frame(24, 4, 3);
    pg_en = 1'b1;

    // R3 grid with wrap, both backgrounds
    mode = 8'h00; h_pos = 2; v_pos = 1; h_step = 3; v_step = 2; h_num = 4; v_num = 3;
    data1 = 12'h100; data2 = 12'h700;
    for (int b = 0; b < 2; b++) begin bg_thru = b[0]; run_frame(24, 10, 5 + b); end
    data1 = 12'h000; data2 = 12'h555; bg_thru = 1'b0; run_frame(24, 10, 11);
    h_pos = 0; v_pos = 0; h_step = 1; v_step = 4; h_num = 5; v_num = 2;
    data1 = 12'hFF0; data2 = 12'h001; run_frame(24, 8, 13);
    h_step = 0; run_frame(12, 3, 17);
    h_step = 1; v_num = 0; run_frame(12, 3, 19);
    v_num = 2;

    // R4 sequences
    mode = 8'h01; run_frame(24, 3, 23);
    mode = 8'h02; run_frame(30, 3, 29);

    // R6 / R7 lines on both backgrounds
    h_pos = 5; v_pos = 3; data1 = 12'h3A5; data2 = 12'h000;
    for (int m = 4; m <= 6; m++) begin
      for (int b = 0; b < 2; b++) begin
        mode = 8'(m); bg_thru = b[0]; run_frame(24, 8, 31 + m * 2 + b);
      end
    end
    data2 = 12'hFFF; mode = 8'h04; bg_thru = 1'b0; run_frame(12, 5, 41);

    // R8 stripes and checkerboard
    data1 = 12'h0F0; data2 = 12'hFFF;
    mode = 8'h07; run_frame(24, 4, 43);
    mode = 8'h08; run_frame(24, 6, 47);

    // R9 colour bars
    bar_width = 8'd2; mode = 8'h0A; run_frame(300, 2, 53);
    mode = 8'h0B; run_frame(4, 290, 59);
    bar_width = 8'd3; mode = 8'h0A; run_frame(120, 1, 61);
    bar_width = 8'd1; run_frame(24, 2, 67);
    bar_width = 8'd0; mode = 8'h0B; run_frame(24, 2, 71);

    // R10 unlisted modes
    foreach (tag[i]) ;
    mode = 8'h09; run_frame(16, 2, 73);
    mode = 8'h0C; run_frame(16, 2, 79);
    mode = 8'hFF; run_frame(16, 2, 83);

    // R5 ramp with wrap for each increment, then the illegal code
    mode = 8'h03;
    for (int g = 0; g < 3; g++) begin grad_step = 2'(g); run_frame(4200, 1, 89 + g); end
    grad_step = 2'd3; run_frame(20, 2, 97);

    finish_run();
  end
endmodule